// File: doc/BRIEF.md
# Peripheral Interrupt Flag Unit

This block keeps a bank of interrupt flags for a single peripheral and drives one interrupt request line from them. A hardware event on an input bit sets the matching flag. Software can read the flags, set chosen flags through a write-one-to-set register, and clear chosen flags through a write-one-to-clear register. A per-flag enable register masks each flag. The enabled flags are ORed together, and the result is registered to form the request line.

The register port is a plain strobe interface. A write takes effect on the clock edge at which `wr_en` is high. Reads are combinational and come from `rd_addr`. The register addresses are: 0 for the raw flags (read only), 1 for set (write only), 2 for clear (write only), and 3 for enable (read/write). The number of flags is a parameter, from 1 to 32.

Top module: `irq_flag_unit`

## Requirements
- R1: A high bit n on `hw_evt` at a rising clock edge sets flag n at that edge.
- R2: A write to address 1 sets every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R3: A write to address 2 clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R4: When a hardware event and a software clear hit the same flag at the same edge, the flag ends up set.
- R5: A write to address 3 replaces the enable register, and reading address 3 returns it.
- R6: Reading address 0 returns the raw flags whatever the enables are. Writes to address 0 change nothing.
- R7: `irq` equals the OR over all n of (flag n AND enable n), taken one clock after that state. It is therefore one cycle behind any flag or enable change.
- R8: After reset, all flags, all enables and `irq` are 0.
- R9: Reading address 1 or address 2 always returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_evt | input | NUM_FLAGS | Hardware event per flag, sets the flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | NUM_FLAGS | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | NUM_FLAGS | Register read data, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets a hardware event landing on the same flag, at the same edge, as a software clear. A design that let the clear win would drop that event and leave the flag low. It writes zero bits to the set and clear registers and expects no flag to move. A design that wrote the register value straight into the flag bank would disturb other flags. It changes an enable while the flag stays fixed, and checks that `irq` follows exactly one cycle later, so a combinational or two-stage request path shows up as a timing mismatch. Random writes, events and reads are checked against a bench model, so a read that applied the enable mask to the raw flags, or a write to the flag address that did anything, is caught.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_FLAG = 2'd0,
    REG_SET  = 2'd1,
    REG_CLR  = 2'd2,
    REG_EN   = 2'd3
  } irqf_reg_e;
endpackage

// File: rtl/irqf_rst_sync.sv
module irqf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/irqf_regif.sv
module irqf_regif
  import irqf_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 8
) (
  input  logic                 clk,
  input  logic                 srst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [NUM_FLAGS-1:0] wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] set_mask,
  output logic [NUM_FLAGS-1:0] clr_mask,
  output logic [NUM_FLAGS-1:0] enables,
  output logic [NUM_FLAGS-1:0] rd_data
);
  logic [NUM_FLAGS-1:0] en_q;
  logic [NUM_FLAGS-1:0] en_d;
  logic                 en_load;

  // write decode
  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    en_load  = 1'b0;
    if (wr_en) begin
      unique case (wr_addr)
        REG_SET: set_mask = wr_data;
        REG_CLR: clr_mask = wr_data;
        REG_EN:  en_load  = 1'b1;
        default: ;
      endcase
    end
  end

  // enable register next state
  always_comb begin
    en_d = en_q;
    if (en_load) en_d = wr_data;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) en_q <= '0;
    else         en_q <= en_d;
  end

  assign enables = en_q;

  // read mux
  always_comb begin
    unique case (rd_addr)
      REG_FLAG: rd_data = flags;
      REG_EN:   rd_data = en_q;
      default:  rd_data = '0;
    endcase
  end

  // R5: enable write takes the written value
  a_r5_en_write: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && wr_addr == REG_EN) |=> (enables == $past(wr_data)));

  a_r5_en_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !(wr_en && wr_addr == REG_EN) |=> $stable(enables));
endmodule

// File: rtl/irqf_flag_cell.sv
module irqf_flag_cell (
  input  logic clk,
  input  logic srst_n,
  input  logic hw_set,
  input  logic sw_set,
  input  logic sw_clr,
  output logic flag
);
  logic flag_q;
  logic flag_d;

  // hardware and software set take priority over software clear
  always_comb begin
    flag_d = flag_q;
    if (sw_clr)          flag_d = 1'b0;
    if (sw_set || hw_set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag = flag_q;

  a_r1_hw_sets: assert property (@(posedge clk) disable iff (!srst_n)
    hw_set |=> flag);

  a_r2_sw_sets: assert property (@(posedge clk) disable iff (!srst_n)
    sw_set |=> flag);

  a_r3_sw_clears: assert property (@(posedge clk) disable iff (!srst_n)
    (sw_clr && !hw_set && !sw_set) |=> !flag);

  a_r4_hw_beats_clr: assert property (@(posedge clk) disable iff (!srst_n)
    (sw_clr && hw_set) |=> flag);

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!srst_n)
    (!sw_clr && !hw_set && !sw_set) |=> $stable(flag));
endmodule

// File: rtl/irqf_combine.sv
module irqf_combine #(
  parameter int unsigned NUM_FLAGS = 8
) (
  input  logic                 clk,
  input  logic                 srst_n,
  input  logic [NUM_FLAGS-1:0] flags,
  input  logic [NUM_FLAGS-1:0] enables,
  output logic                 irq
);
  logic irq_q;
  logic irq_d;

  always_comb irq_d = |(flags & enables);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq = irq_q;

  a_r7_irq_lag: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> (irq == |($past(flags) & $past(enables))));

  a_r7_no_enable_no_irq: assert property (@(posedge clk) disable iff (!srst_n)
    (enables == '0) |=> !irq);
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irqf_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] hw_evt,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [NUM_FLAGS-1:0] wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [NUM_FLAGS-1:0] rd_data,
  output logic                 irq
);
  logic                 srst_n;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] enables;
  logic [NUM_FLAGS-1:0] set_mask;
  logic [NUM_FLAGS-1:0] clr_mask;

  initial begin : p_param_chk
    assert (NUM_FLAGS >= 1 && NUM_FLAGS <= 32)
      else $error("NUM_FLAGS out of range");
  end

  irqf_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  irqf_regif #(.NUM_FLAGS(NUM_FLAGS)) u_regif (
    .clk      (clk),
    .srst_n   (srst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .flags    (flags),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .enables  (enables),
    .rd_data  (rd_data)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    irqf_flag_cell u_cell (
      .clk    (clk),
      .srst_n (srst_n),
      .hw_set (hw_evt[i]),
      .sw_set (set_mask[i]),
      .sw_clr (clr_mask[i]),
      .flag   (flags[i])
    );
  end

  irqf_combine #(.NUM_FLAGS(NUM_FLAGS)) u_comb (
    .clk     (clk),
    .srst_n  (srst_n),
    .flags   (flags),
    .enables (enables),
    .irq     (irq)
  );

  // R8: state is clear while held in reset
  a_r8_reset_quiet: assert property (@(posedge clk)
    !srst_n |-> (flags == '0 && enables == '0 && !irq));

  // R9: set and clear addresses read back as zero
  a_r9_wo_reads_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_addr == REG_SET || rd_addr == REG_CLR) |-> (rd_data == '0));
endmodule

// File: tb/tb_irq_flag_unit.sv
module tb_irq_flag_unit;
  localparam int unsigned N = 8;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] hw_evt;
  logic         wr_en;
  logic [1:0]   wr_addr;
  logic [N-1:0] wr_data;
  logic [1:0]   rd_addr;
  logic [N-1:0] rd_data;
  logic         irq;

  int n_tests;
  int n_fail;
  bit done;

  logic [N-1:0] m_flag;
  logic [N-1:0] m_en;
  logic         m_irq;

  irq_flag_unit #(.NUM_FLAGS(N)) dut (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic calc_irq(logic [N-1:0] f, logic [N-1:0] e);
    return |(f & e);
  endfunction

  function automatic logic [N-1:0] calc_flags(logic [N-1:0] f, logic [N-1:0] hw,
                                              logic we, logic [1:0] a, logic [N-1:0] d);
    logic [N-1:0] r;
    r = f;
    if (we && a == 2'd1) r = r | d;
    if (we && a == 2'd2) r = r & ~d;
    return r | hw;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, then check irq and the readable registers.
  task automatic step(logic [N-1:0] hw, logic we, logic [1:0] a, logic [N-1:0] d,
                      string ftag, string etag);
    hw_evt  = hw;
    wr_en   = we;
    wr_addr = a;
    wr_data = d;
    @(posedge clk);
    m_irq  = calc_irq(m_flag, m_en);
    m_flag = calc_flags(m_flag, hw, we, a, d);
    if (we && a == 2'd3) m_en = d;
    @(negedge clk);
    hw_evt = '0;
    wr_en  = 1'b0;
    check("R7 irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_irq});
    rd_addr = 2'd0; #1;
    check(ftag, rd_data, m_flag);
    rd_addr = 2'd3; #1;
    check(etag, rd_data, m_en);
    rd_addr = (($urandom & 1) != 0) ? 2'd1 : 2'd2; #1;
    check("R9 write-only read", rd_data, '0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    n_tests = 0; n_fail = 0; done = 1'b0;
    void'($urandom(32'h5eed_1234));
    hw_evt = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    m_flag = '0; m_en = '0; m_irq = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 reset state
    check("R8 irq after reset", {{(N-1){1'b0}}, irq}, '0);
    rd_addr = 2'd0; #1; check("R8 flags after reset", rd_data, '0);
    rd_addr = 2'd3; #1; check("R8 enables after reset", rd_data, '0);

    // R1 hardware event sets flag, not enabled: no irq
    step(8'h05, 1'b0, 2'd0, '0, "R1 hw set", "R5 en");
    // R6 raw flags readable with no enable, R5 enable write
    step('0, 1'b1, 2'd3, 8'h04, "R6 raw flags", "R5 enable write");
    step('0, 1'b0, 2'd0, '0, "R6 raw flags", "R5 enable hold");
    // R7 enable removed: irq drops next cycle
    step('0, 1'b1, 2'd3, 8'h00, "R6 raw flags", "R5 enable clear");
    step('0, 1'b0, 2'd0, '0, "R6 raw flags", "R5 en");
    // R2 write-one-to-set, zeros no effect
    step('0, 1'b1, 2'd1, 8'h80, "R2 set", "R5 en");
    step('0, 1'b1, 2'd1, 8'h00, "R2 zero set no effect", "R5 en");
    // R3 write-one-to-clear, zeros no effect
    step('0, 1'b1, 2'd2, 8'h00, "R3 zero clear no effect", "R5 en");
    step('0, 1'b1, 2'd2, 8'h01, "R3 clear", "R5 en");
    // R6 write to flag address ignored
    step('0, 1'b1, 2'd0, 8'hff, "R6 flag write ignored", "R5 en");
    // R4 hw set beats sw clear on same bit
    step(8'h84, 1'b1, 2'd2, 8'h84, "R4 hw wins over clear", "R5 en");
    step('0, 1'b1, 2'd3, 8'hff, "R4 flag kept", "R5 enable all");
    step('0, 1'b1, 2'd2, 8'hff, "R3 clear all", "R5 en");
    step('0, 1'b0, 2'd0, '0, "R3 cleared", "R5 en");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] hw;
      logic [1:0]   a;
      hw = (($urandom % 4) == 0) ? N'($urandom) & N'($urandom) : '0;
      a  = 2'($urandom);
      step(hw, ($urandom % 3) != 0, a, N'($urandom), "R6 random flags", "R5 random en");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule